// File: doc/BRIEF.md
# Asynchronous Parallel Slave Port

An 8-bit port through which an external microprocessor reads and writes a pair of data latches. The host has no clock of its own on this interface. It drives an active-low chip select with active-low write and read strobes. The block brings those three pins into the local clock domain through a flop synchronizer. It detects the end of each host access from the rising edge of the select or of the strobe, so it does not work on the level of these pins.

The local side is a synchronous register port that offers these operations:
- write the outgoing byte;
- read the incoming byte;
- read or write a status/control byte;
- clear the interrupt flag.

A free-running four-phase counter marks an instruction cycle. Flag updates that follow a host access are held back until the fourth phase that comes after the next second phase. The block tracks three flags: one for a received byte, one for a byte waiting to be read, and one for an overflow. A latched interrupt flag, gated by an enable input, tells the local CPU that a host access has completed.

Top module: `pport_slave`

## Requirements
- R1: A host write starts when the synchronized select and write strobe are both low. It completes only on the rising edge of either pin. While both pins stay low, no flag changes. On completion, the byte captured during the access goes to the incoming latch.
- R2: When a host write completes, the received flag (status bit 7) and the interrupt flag are set together. They are set on the clock edge that ends phase 4 (counter value 3) of the instruction cycle that follows the next phase 2 (counter value 1) after the edge is detected.
- R3: Suppose a host write completes while the received flag is still 1. Then the overflow flag (status bit 5) is set and the incoming latch keeps its earlier byte.
- R4: A local read with cpu_sel=0 returns the incoming latch and clears the received flag. A status write cannot change the received flag or the waiting flag.
- R5: A local write with cpu_sel=0 loads the outgoing latch and sets the waiting flag (status bit 6). That flag clears as soon as a host read starts, with select and read strobe low. While that host read lasts in port mode, ext_data_oe is 1 and ext_data_out carries the outgoing latch. Otherwise ext_data_oe is 0.
- R6: When a host read completes, on a rising select or read strobe, the interrupt flag is set with the same phase alignment as R2. The waiting flag stays 0 until the next local write of the outgoing latch.
- R7: A status read returns received at bit 7, waiting at bit 6, overflow at bit 5 and port-mode enable at bit 4, with bits 3:0 as zero. A status write changes only bits 5 and 4.
- R8: While port mode (status bit 4) is 0, the received and waiting flags read 0 and host strobes have no effect. An overflow flag that is already set stays set until software writes it to 0.
- R9: The interrupt flag is cleared only by a cpu_irq_clr pulse. The irq output is 1 exactly when the flag is 1 and irq_en is 1.
- R10: After reset, port mode is off, every flag is 0, irq is 0 and ext_data_oe is 0.
- R11: Once the received flag is set, local reads of the incoming latch cannot clear it for PHASE_CNT clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_cs_n | input | 1 | Host chip select, active low, asynchronous |
| ext_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| ext_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| ext_data_in | input | DATA_W | Host data bus as seen by the port |
| ext_data_out | output | DATA_W | Outgoing latch presented to the host bus |
| ext_data_oe | output | 1 | Host bus drive enable |
| cpu_sel | input | 1 | 0 selects the data latches, 1 the status/control byte |
| cpu_wr | input | 1 | Local write strobe for one cycle |
| cpu_rd | input | 1 | Local read strobe for one cycle |
| cpu_wdata | input | DATA_W | Local write data |
| cpu_rdata | output | DATA_W | Local read data, valid the cycle after cpu_rd |
| cpu_irq_clr | input | 1 | Clears the interrupt flag |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Gated interrupt request |

## Verification
The hardest case to reach is the race between the received flag being set and a local read trying to clear it. Reaching it needs a host write whose completion lands on a known phase, then a local read issued within a cycle of the flag rising. The bench polls irq on every cycle after the host releases its strobes, and fires the data read in the same cycle the interrupt is first seen. Random sequences also mix host writes that end on select against writes that end on the strobe, overflowing writes, and host reads that overlap local status reads.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int unsigned STAT_IBF  = 7;
  localparam int unsigned STAT_OBF  = 6;
  localparam int unsigned STAT_OVF  = 5;
  localparam int unsigned STAT_MODE = 4;
  localparam int unsigned STAT_W    = 8;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= {WIDTH{RST_VAL}};
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= {WIDTH{RST_VAL}};
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pport_phase.sv
module pport_phase #(
  parameter int unsigned PHASE_CNT = 4,
  parameter int unsigned ARM_PH    = 1
) (
  input  logic clk,
  input  logic rst,
  output logic arm_ph,
  output logic set_ph
);
  localparam int unsigned PW     = (PHASE_CNT > 1) ? $clog2(PHASE_CNT) : 1;
  localparam int unsigned SET_PH = PHASE_CNT - 1;

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (cnt == PW'(SET_PH))      cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  assign arm_ph = (cnt == PW'(ARM_PH));
  assign set_ph = (cnt == PW'(SET_PH));
endmodule

// File: rtl/pport_access.sv
module pport_access (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic sel_n,
  input  logic strb_n,
  input  logic arm_ph,
  input  logic set_ph,
  output logic active,
  output logic start,
  output logic commit
);
  logic act_q;
  logic finish;
  logic pend_q;
  logic armed_q;

  assign active = enable & ~sel_n & ~strb_n;
  assign start  = active & ~act_q;
  assign finish = enable & act_q & ~active;
  assign commit = armed_q & set_ph;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= active;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (finish)                pend_q <= 1'b1;
      else if (pend_q && arm_ph) pend_q <= 1'b0;

      if (pend_q && arm_ph)      armed_q <= 1'b1;
      else if (armed_q && set_ph) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pport_slave.sv
module pport_slave
  import pport_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PHASE_CNT   = 4,
  parameter int unsigned IBF_HOLD    = PHASE_CNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_cs_n,
  input  logic              ext_wr_n,
  input  logic              ext_rd_n,
  input  logic [DATA_W-1:0] ext_data_in,
  output logic [DATA_W-1:0] ext_data_out,
  output logic              ext_data_oe,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              cpu_irq_clr,
  input  logic              irq_en,
  output logic              irq
);
  localparam int unsigned HW = $clog2(IBF_HOLD + 1);

  logic [2:0]        pins_s;
  logic              cs_s, wr_s, rd_s;
  logic              arm_ph, set_ph;
  logic              wr_active, wr_start, wr_commit;
  logic              rd_active, rd_start, rd_commit;
  logic              unused_acc;

  logic              ibf_q, obf_q, ovf_q, mode_q, int_flag_q;
  logic [HW-1:0]     hold_cnt;
  logic [DATA_W-1:0] wr_buf, in_latch_q, out_latch_q;
  logic [DATA_W-1:0] status;

  logic data_rd, data_wr, stat_wr, accept;

  pport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ext_cs_n, ext_wr_n, ext_rd_n}),
    .q   (pins_s)
  );
  assign cs_s = pins_s[2];
  assign wr_s = pins_s[1];
  assign rd_s = pins_s[0];

  pport_phase #(.PHASE_CNT(PHASE_CNT), .ARM_PH(1)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .arm_ph (arm_ph),
    .set_ph (set_ph)
  );

  pport_access u_wr_acc (
    .clk    (clk),
    .rst    (rst),
    .enable (mode_q),
    .sel_n  (cs_s),
    .strb_n (wr_s),
    .arm_ph (arm_ph),
    .set_ph (set_ph),
    .active (wr_active),
    .start  (wr_start),
    .commit (wr_commit)
  );

  pport_access u_rd_acc (
    .clk    (clk),
    .rst    (rst),
    .enable (mode_q),
    .sel_n  (cs_s),
    .strb_n (rd_s),
    .arm_ph (arm_ph),
    .set_ph (set_ph),
    .active (rd_active),
    .start  (rd_start),
    .commit (rd_commit)
  );

  assign unused_acc = wr_start ^ rd_active;

  assign data_rd = cpu_rd & ~cpu_sel;
  assign data_wr = cpu_wr & ~cpu_sel;
  assign stat_wr = cpu_wr &  cpu_sel;
  assign accept  = wr_commit & ~ibf_q;

  always_comb begin
    status            = '0;
    status[STAT_IBF]  = ibf_q;
    status[STAT_OBF]  = obf_q;
    status[STAT_OVF]  = ovf_q;
    status[STAT_MODE] = mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst)            wr_buf <= '0;
    else if (wr_active) wr_buf <= ext_data_in;
  end

  always_ff @(posedge clk) begin
    if (rst)         in_latch_q <= '0;
    else if (accept) in_latch_q <= wr_buf;
  end

  always_ff @(posedge clk) begin
    if (rst)          out_latch_q <= '0;
    else if (data_wr) out_latch_q <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (stat_wr) begin
        mode_q <= cpu_wdata[STAT_MODE];
        ovf_q  <= cpu_wdata[STAT_OVF];
      end
      if (wr_commit && ibf_q) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !mode_q) begin
      ibf_q    <= 1'b0;
      hold_cnt <= '0;
    end else if (accept) begin
      ibf_q    <= 1'b1;
      hold_cnt <= HW'(IBF_HOLD);
    end else begin
      if (data_rd && hold_cnt == '0) ibf_q <= 1'b0;
      if (hold_cnt != '0)            hold_cnt <= hold_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !mode_q) obf_q <= 1'b0;
    else if (data_wr)   obf_q <= 1'b1;
    else if (rd_start)  obf_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                         int_flag_q <= 1'b0;
    else if (wr_commit || rd_commit) int_flag_q <= 1'b1;
    else if (cpu_irq_clr)            int_flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)         cpu_rdata <= '0;
    else if (cpu_rd) cpu_rdata <= cpu_sel ? status : in_latch_q;
  end

  assign irq          = int_flag_q & irq_en;
  assign ext_data_out = out_latch_q;
  assign ext_data_oe  = mode_q & ~ext_cs_n & ~ext_rd_n;
endmodule

// File: rtl/pport_slave_chk.sv
module pport_slave_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ibf,
  input logic              obf,
  input logic              ovf,
  input logic              mode,
  input logic              int_flag,
  input logic              set_ph,
  input logic              rd_start,
  input logic [DATA_W-1:0] in_latch,
  input logic              cpu_sel,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              irq_en,
  input logic              irq,
  input logic              ext_data_oe
);
  AST_IBF_ON_PHASE4: assert property (@(posedge clk) disable iff (rst)
    $rose(ibf) |-> $past(set_ph)); // R2
  AST_IBF_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(ibf) |-> int_flag); // R2
  AST_OVF_KEEPS_BYTE: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $stable(in_latch)); // R3
  AST_IBF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    $rose(ibf) |=> ibf); // R11
  AST_OBF_DROPS: assert property (@(posedge clk) disable iff (rst)
    (rd_start && !(cpu_wr && !cpu_sel)) |=> !obf); // R5
  AST_OE_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    ext_data_oe |-> mode); // R5
  AST_MODE_OFF_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (!mode && $past(!mode)) |-> (!ibf && !obf)); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> irq_en); // R9
  AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(cpu_rd && cpu_sel) |-> (cpu_rdata[3:0] == 4'h0)); // R7
endmodule

bind pport_slave pport_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ibf         (ibf_q),
  .obf         (obf_q),
  .ovf         (ovf_q),
  .mode        (mode_q),
  .int_flag    (int_flag_q),
  .set_ph      (set_ph),
  .rd_start    (rd_start),
  .in_latch    (in_latch_q),
  .cpu_sel     (cpu_sel),
  .cpu_wr      (cpu_wr),
  .cpu_rd      (cpu_rd),
  .cpu_rdata   (cpu_rdata),
  .irq_en      (irq_en),
  .irq         (irq),
  .ext_data_oe (ext_data_oe)
);

// File: tb/tb_pport_slave.sv
module tb_pport_slave;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_cs_n = 1'b1, ext_wr_n = 1'b1, ext_rd_n = 1'b1;
  logic [DW-1:0] ext_data_in = '0;
  logic [DW-1:0] ext_data_out;
  logic ext_data_oe;
  logic cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic cpu_irq_clr = 1'b0;
  logic irq_en = 1'b1;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic m_ibf = 0, m_obf = 0, m_ovf = 0, m_mode = 0, m_flag = 0;
  logic [DW-1:0] m_in = '0, m_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pport_slave dut (
    .clk(clk), .rst(rst),
    .ext_cs_n(ext_cs_n), .ext_wr_n(ext_wr_n), .ext_rd_n(ext_rd_n),
    .ext_data_in(ext_data_in), .ext_data_out(ext_data_out), .ext_data_oe(ext_data_oe),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_irq_clr(cpu_irq_clr), .irq_en(irq_en), .irq(irq)
  );

  function automatic logic [DW-1:0] exp_status(logic ibf, logic obf, logic ovf, logic mode);
    return {ibf, obf, ovf, mode, 4'h0};
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(logic sel, logic [DW-1:0] d);
    @(negedge clk);
    cpu_sel = sel; cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(logic sel, output logic [DW-1:0] d);
    @(negedge clk);
    cpu_sel = sel; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic irq_clear();
    @(negedge clk);
    cpu_irq_clr = 1'b1;
    @(negedge clk);
    cpu_irq_clr = 1'b0;
  endtask

  task automatic ext_write(logic [DW-1:0] d, logic cs_first);
    @(negedge clk);
    ext_data_in = d; ext_cs_n = 1'b0; ext_wr_n = 1'b0;
    repeat (6) @(negedge clk);
    if (cs_first) ext_cs_n = 1'b1; else ext_wr_n = 1'b1;
    @(negedge clk);
    ext_cs_n = 1'b1; ext_wr_n = 1'b1;
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic ext_read(string req, logic [DW-1:0] exp_d, logic exp_oe);
    @(negedge clk);
    ext_cs_n = 1'b0; ext_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(req, ext_data_oe, exp_oe);
    if (exp_oe) chk(req, ext_data_out, exp_d);
    if ($urandom_range(1, 0) == 1) ext_rd_n = 1'b1; else ext_cs_n = 1'b1;
    @(negedge clk);
    ext_cs_n = 1'b1; ext_rd_n = 1'b1;
    chk(req, ext_data_oe, 1'b0);
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic check_status(string req);
    logic [DW-1:0] s;
    cpu_read(1'b1, s);
    chk(req, s, exp_status(m_ibf, m_obf, m_ovf, m_mode));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    summary();
  end

  initial begin : main
    logic [DW-1:0] d;
    logic seen;
    void'($urandom(32'h5A17));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    check_status("R10 status after reset");
    chk("R10 irq after reset", irq, 1'b0);
    chk("R10 oe after reset", ext_data_oe, 1'b0);

    // R7 writable bits only
    cpu_write(1'b1, 8'hFF);
    m_mode = 1; m_ovf = 1;
    check_status("R7 status write masks bits 7,6,3:0");
    cpu_write(1'b1, 8'h10);
    m_ovf = 0;
    check_status("R7 overflow cleared by status write");

    // R1 level held low gives nothing, wr rising completes
    @(negedge clk);
    ext_data_in = 8'hA5; ext_cs_n = 1'b0; ext_wr_n = 1'b0;
    repeat (30) @(negedge clk);
    chk("R1 no completion while strobes low (irq)", irq, 1'b0);
    check_status("R1 no completion while strobes low (status)");
    ext_wr_n = 1'b1;
    @(negedge clk);
    ext_cs_n = 1'b1;
    repeat (SETTLE) @(negedge clk);
    m_ibf = 1; m_in = 8'hA5; m_flag = 1;
    chk("R2 irq set after write completion", irq, 1'b1);
    check_status("R2 received flag set");

    // R4 data read clears received flag
    cpu_read(1'b0, d);
    chk("R4 data read value", d, 8'hA5);
    m_ibf = 0;
    check_status("R4 received flag cleared");

    // R4 status write cannot touch ibf/obf
    cpu_write(1'b1, 8'hD0);
    check_status("R4 status write leaves flags 7,6");

    // R1 completion on CS rising, R9 clear
    irq_clear(); m_flag = 0;
    chk("R9 irq cleared", irq, 1'b0);
    ext_write(8'h3C, 1'b1);
    m_ibf = 1; m_in = 8'h3C; m_flag = 1;
    chk("R1 cs rising completes (irq)", irq, 1'b1);

    // R3 overflow keeps first byte
    ext_write(8'h99, 1'b0);
    m_ovf = 1;
    check_status("R3 overflow set");
    cpu_read(1'b0, d);
    chk("R3 first byte preserved", d, 8'h3C);
    m_ibf = 0;
    cpu_write(1'b1, 8'h10); m_ovf = 0;

    // R11 read right after flag set is ignored
    irq_clear(); m_flag = 0;
    @(negedge clk);
    ext_data_in = 8'h5E; ext_cs_n = 1'b0; ext_wr_n = 1'b0;
    repeat (6) @(negedge clk);
    ext_cs_n = 1'b1; ext_wr_n = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 30 && !seen; i++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    chk("R2 irq rises within window", seen, 1'b1);
    cpu_rd = 1'b1; cpu_sel = 1'b0;
    @(negedge clk);
    cpu_rd = 1'b0;
    chk("R11 early read data", cpu_rdata, 8'h5E);
    m_ibf = 1; m_in = 8'h5E; m_flag = 1;
    check_status("R11 received flag survives early read");
    repeat (6) @(negedge clk);
    cpu_read(1'b0, d); m_ibf = 0;
    check_status("R11 later read clears");

    // R5 / R6 host read
    cpu_write(1'b0, 8'hC3); m_out = 8'hC3; m_obf = 1;
    check_status("R5 waiting flag set");
    irq_clear(); m_flag = 0;
    @(negedge clk);
    ext_cs_n = 1'b0; ext_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 oe during host read", ext_data_oe, 1'b1);
    chk("R5 data during host read", ext_data_out, 8'hC3);
    m_obf = 0;
    check_status("R5 waiting flag cleared at read start");
    chk("R6 no irq before completion", irq, 1'b0);
    ext_rd_n = 1'b1;
    @(negedge clk);
    ext_cs_n = 1'b1;
    chk("R5 oe released", ext_data_oe, 1'b0);
    repeat (SETTLE) @(negedge clk);
    m_flag = 1;
    chk("R6 irq after read completion", irq, 1'b1);
    check_status("R6 waiting flag stays clear");

    // R9 enable gating
    irq_en = 1'b0;
    @(negedge clk);
    chk("R9 irq masked", irq, 1'b0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R9 irq unmasked", irq, 1'b1);
    irq_clear(); m_flag = 0;

    // R8 mode off
    ext_write(8'h11, 1'b0); m_ibf = 1; m_in = 8'h11; m_flag = 1;
    ext_write(8'h22, 1'b0); m_ovf = 1;
    cpu_write(1'b0, 8'h77); m_out = 8'h77; m_obf = 1;
    irq_clear(); m_flag = 0;
    cpu_write(1'b1, 8'h20); m_mode = 0; m_ibf = 0; m_obf = 0;
    check_status("R8 flags held, overflow persists");
    ext_write(8'h44, 1'b0);
    chk("R8 host write ignored (irq)", irq, 1'b0);
    cpu_read(1'b0, d);
    chk("R8 host write ignored (latch)", d, 8'h11);
    ext_read("R8 no drive when mode off", 8'h00, 1'b0);
    chk("R8 host read ignored (irq)", irq, 1'b0);
    cpu_write(1'b1, 8'h10); m_mode = 1; m_ovf = 0;
    check_status("R8 overflow cleared by software");

    // random mix
    for (int n = 0; n < 300; n++) begin
      int op;
      logic [DW-1:0] r;
      op = $urandom_range(5, 0);
      r = DW'($urandom);
      case (op)
        0: begin
          ext_write(r, $urandom_range(1, 0) == 1);
          if (m_ibf) m_ovf = 1; else begin m_in = r; m_ibf = 1; end
          m_flag = 1;
          chk("R1 random host write irq", irq, m_flag);
        end
        1: begin
          cpu_read(1'b0, d);
          chk("R4 random data read", d, m_in);
          m_ibf = 0;
        end
        2: begin
          cpu_write(1'b0, r); m_out = r; m_obf = 1;
        end
        3: begin
          ext_read("R5 random host read", m_out, 1'b1);
          m_obf = 0; m_flag = 1;
          chk("R6 random read irq", irq, m_flag);
        end
        4: begin
          irq_clear(); m_flag = 0;
          chk("R9 random clear", irq, 1'b0);
        end
        default: begin
          if (m_ovf && $urandom_range(1, 0) == 1) begin
            cpu_write(1'b1, 8'h10); m_ovf = 0;
          end
          check_status("R7 random status");
        end
      endcase
    end

    summary();
  end
endmodule